// File: doc/BRIEF.md
# Prescaled Compare PWM Generator

A single-channel pulse-width modulator for a microcontroller peripheral bus. A free-running toggle halves the input clock, an 8-bit reloading prescaler further divides that base rate, and the resulting tick advances an 8-bit counter that wraps after 255 steps (values 0 through 254). The counter is compared against a compare value, giving duty cycles in steps of 1/255. The compare value 0 gives a constant high output and the compare value 255 gives a constant low output.

Software writes the prescaler, the compare value and a control byte through a simple write port. A new compare value is held in a shadow copy and only takes effect when the counter wraps, so no partial pulse appears mid-period. Each wrap sets a sticky overflow flag. This flag drives a maskable interrupt request. Because the counter keeps running while the pin drive is released, the block also serves as an interval timer. An idle or power-down request freezes the whole divide chain and forces the output high.

Top module: `pwm_cmp_gen`

## Requirements
- R1: The counter advances once every 2*(1+P) clock cycles, where P is the prescaler value. The output period is therefore 2*(1+P)*255 clock cycles, and a prescaler change applies from the next prescaler reload.
- R2: The counter steps by one from 0 to 254 and then returns to 0. It never holds 255.
- R3: While the output is running, pwm_o is low when the counter is below the active compare value C and high otherwise. The high time per period is 2*(1+P)*(255-C) cycles, C=0 holds pwm_o high and C=255 holds pwm_o low.
- R4: A compare value written at address 1 is copied into the active compare only when the counter wraps to 0. The output keeps the old duty until then.
- R5: Writes use wr_addr_i with wr_data_i: address 0 holds the prescaler, address 1 holds the compare value, and address 2 holds the control byte (bit 0 is the output enable, bit 1 is the interrupt enable). pwm_oe_o equals the output enable bit.
- R6: When the output enable is clear, the prescaler, the counter and the overflow flag keep running.
- R7: While idle_i or pdown_i is high, the half-rate toggle, the prescaler and the counter hold their values and pwm_o is high.
- R8: Each counter wrap sets the overflow flag. The flag stays set until a write to address 3 with data bit 0 equal to 1 clears it.
- R9: irq_o is high exactly when the overflow flag is set and the interrupt enable (control bit 1) is set. A flag raised while masked appears on irq_o as soon as the mask is lifted.
- R10: After reset the prescaler, the compare, the control bits and the flag are zero. So pwm_oe_o=0, irq_o=0 and pwm_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Idle request: freezes counting, forces output high |
| pdown_i | input | 1 | Power-down request: same effect as idle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 prescaler, 1 compare, 2 control, 3 flag clear) |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | Modulated output level |
| pwm_oe_o | output | 1 | Output drive enable |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The duty function is tried with random prescaler and compare pairs. It is also tried with the directed compare values 0, 1, 254 and 255, and the high cycles are counted over exactly one expected period. A wrong period, an off-by-one wrap point or a wrong comparison direction all shift that count, while the extremes separate the constant-level cases from a one-step pulse. A mid-period compare change tells a shadowed compare from an immediate one. Runs with the output disabled, with the interrupt masked and with idle or power-down asserted tell whether counting, flagging and output forcing are coupled to the right controls.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [1:0] {
    ADDR_PRESC = 2'd0,
    ADDR_CMP   = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_CLR   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic out_en;
  } ctrl_t;
endpackage

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [PRE_W-1:0]  presc_o,
  output logic [CNT_W-1:0]  cmp_o,
  output ctrl_t             ctrl_o,
  output logic              clr_o
);
  reg_addr_e addr;
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] cmp_q;
  ctrl_t            ctrl_q;

  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cmp_q   <= '0;
      ctrl_q  <= '0;
    end else if (wr_en_i) begin
      case (addr)
        ADDR_PRESC: presc_q <= PRE_W'(wr_data_i);
        ADDR_CMP:   cmp_q   <= CNT_W'(wr_data_i);
        ADDR_CTRL:  ctrl_q  <= ctrl_t'(wr_data_i[1:0]);
        default:    ;
      endcase
    end
  end

  assign presc_o = presc_q;
  assign cmp_o   = cmp_q;
  assign ctrl_o  = ctrl_q;
  assign clr_o   = wr_en_i && (addr == ADDR_CLR) && wr_data_i[0];
endmodule

// File: rtl/pwm_cmp_prescale.sv
module pwm_cmp_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic             half_q;
  logic [PRE_W-1:0] pre_q;
  logic             base_tick;

  // base rate is clk/2, produced as an enable, not a derived clock
  assign base_tick = half_q && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      pre_q  <= '0;
    end else if (!stop_i) begin
      half_q <= !half_q;
      if (base_tick) begin
        if (pre_q == '0) pre_q <= presc_i;
        else             pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign tick_o = base_tick && (pre_q == '0);
endmodule

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             wrap_o,
  output logic             level_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'((2 ** CNT_W) - 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_act_q;

  assign wrap_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cmp_act_q <= '0;
    end else if (tick_i) begin
      if (wrap_o) begin
        cnt_q     <= '0;
        cmp_act_q <= cmp_i;  // shadow load only at period start
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // all-ones compare never matches a count that stops one short of it
  assign level_o   = (cnt_q >= cmp_act_q);
  assign cnt_o     = cnt_q;
  assign cmp_act_o = cmp_act_q;
endmodule

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen
  import pwm_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              irq_o
);
  logic [PRE_W-1:0] presc_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_act_w;
  ctrl_t            ctrl_w;
  logic             clr_w;
  logic             stop_w;
  logic             tick_w;
  logic             wrap_w;
  logic             level_w;
  logic             flag_q;

  assign stop_w = idle_i || pdown_i;

  pwm_cmp_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .presc_o  (presc_w),
    .cmp_o    (cmp_w),
    .ctrl_o   (ctrl_w),
    .clr_o    (clr_w)
  );

  pwm_cmp_prescale #(.PRE_W(PRE_W)) pre_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stop_i (stop_w),
    .presc_i(presc_w),
    .tick_o (tick_w)
  );

  pwm_cmp_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .cmp_i    (cmp_w),
    .cnt_o    (cnt_w),
    .cmp_act_o(cmp_act_w),
    .wrap_o   (wrap_w),
    .level_o  (level_w)
  );

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (wrap_w) flag_q <= 1'b1;
    else if (clr_w)  flag_q <= 1'b0;
  end

  assign pwm_o    = stop_w ? 1'b1 : level_w;
  assign pwm_oe_o = ctrl_w.out_en;
  assign irq_o    = flag_q && ctrl_w.irq_en;
endmodule

// File: rtl/pwm_cmp_gen_chk.sv
module pwm_cmp_gen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             pdown_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_act_i,
  input logic             flag_i,
  input logic             clr_i,
  input logic             pwm_i,
  input logic             oe_i
);
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i != '1);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> ((cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == '0)));

  assert_cmp_at_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_act_i) |-> (cnt_i == '0));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i || pdown_i) |=> $stable(cnt_i));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !clr_i) |=> flag_i);

  assert_flag_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> (cnt_i == '0));

  assert_cmp_zero_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && cmp_act_i == '0) |-> pwm_i);
endmodule

bind pwm_cmp_gen pwm_cmp_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .idle_i   (idle_i),
  .pdown_i  (pdown_i),
  .cnt_i    (cnt_w),
  .cmp_act_i(cmp_act_w),
  .flag_i   (flag_q),
  .clr_i    (clr_w),
  .pwm_i    (pwm_o),
  .oe_i     (pwm_oe_o)
);

// File: tb/pwm_cmp_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_cmp_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm, pwm_oe, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_cmp_gen dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .idle_i   (idle),
    .pdown_i  (pdown),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .pwm_o    (pwm),
    .pwm_oe_o (pwm_oe),
    .irq_o    (irq)
  );

  function automatic int exp_period(int p);
    return 2 * (1 + p) * 255;
  endfunction

  function automatic int exp_high(int p, int c);
    return 2 * (1 + p) * (255 - c);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // clear flag then wait for the next wrap to show on irq_o; returns 0 on timeout
  task automatic wait_wrap(output bit ok);
    wr(3, 1);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
  endtask

  task automatic duty_trial(int p, int c, string req);
    bit ok;
    int hi;
    wr(0, p);
    wr(1, c);
    wr(2, 3);
    wait_wrap(ok);
    wait_wrap(ok);
    check({req, " wrap seen"}, int'(ok), 1);
    count_high(exp_period(p), hi);
    check(req, hi, exp_high(p, c));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int hi;
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 oe", int'(pwm_oe), 0);
    check("R10 irq", int'(irq), 0);
    check("R10 pwm", int'(pwm), 1);

    // R1 R3 directed extremes
    duty_trial(0, 0, "R3 cmp0 high");
    duty_trial(1, 255, "R3 cmp255 low");
    duty_trial(0, 1, "R3 cmp1");
    duty_trial(2, 254, "R3 cmp254");
    check("R5 oe on", int'(pwm_oe), 1);

    // R1 R2 R3 random pairs
    for (int t = 0; t < 6; t++) begin
      int p = int'($urandom_range(0, 3));
      int c = int'($urandom_range(1, 254));
      duty_trial(p, c, "R1 R2 R3 random");
    end

    // R4 shadowed compare
    duty_trial(0, 255, "R4 setup");
    wait_wrap(ok);
    repeat (100) @(negedge clk);
    wr(1, 0);
    check("R4 old duty kept", int'(pwm), 0);
    repeat (50) @(negedge clk);
    check("R4 old duty kept later", int'(pwm), 0);
    wait_wrap(ok);
    check("R4 wrap", int'(ok), 1);
    check("R4 new duty at wrap", int'(pwm), 1);

    // R6 disabled output, counter still runs
    wr(2, 2);
    check("R5 oe off", int'(pwm_oe), 0);
    wait_wrap(ok);
    check("R6 wrap while disabled", int'(ok), 1);

    // R8 sticky flag
    repeat (600) @(negedge clk);
    check("R8 flag sticky", int'(irq), 1);
    wr(3, 1);
    check("R8 flag cleared", int'(irq), 0);

    // R9 masking
    wr(2, 1);
    repeat (exp_period(0) + 20) @(negedge clk);
    check("R9 masked", int'(irq), 0);
    wr(2, 3);
    check("R9 pending shown", int'(irq), 1);

    // R7 idle and power-down
    wr(1, 255);
    wait_wrap(ok);
    wr(3, 1);
    check("R7 low before idle", int'(pwm), 0);
    idle = 1'b1;
    @(negedge clk);
    check("R7 idle high", int'(pwm), 1);
    repeat (exp_period(0) * 3) @(negedge clk);
    check("R7 idle frozen", int'(irq), 0);
    idle = 1'b0;
    pdown = 1'b1;
    @(negedge clk);
    check("R7 pdown high", int'(pwm), 1);
    repeat (exp_period(0) * 2) @(negedge clk);
    check("R7 pdown frozen", int'(irq), 0);
    pdown = 1'b0;
    hi = 0;
    for (int i = 0; i < exp_period(0) + 20; i++) begin
      @(negedge clk);
      if (irq) begin hi = 1; break; end
    end
    check("R7 resumes", hi, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule